// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block turns eight interrupt request inputs into a vector of pending bits. Each line has its own trigger-mode bit. When the bit is 1 the line is level-sensitive, and its pending bit tracks the input. When the bit is 0 the line is edge-sensitive, and its pending bit is set by a rising edge and held until that line is acknowledged. The block keeps the level sampled on the previous clock for every line, and uses it to find rising edges.

Software writes the trigger-mode register through a write strobe. Bits that the instance marks as fixed stay at zero whatever is written, so those lines are always edge-sensitive. A primary instance (`SECONDARY = 0`) may write lines 3 to 7, which is mask 0xF8. A secondary instance may write lines 1 to 4, 6 and 7, which is mask 0xDE.

A mask vector from outside is applied every cycle. A request on a masked line still sets its pending bit, but the block reports it as blocked instead of accepted. An accepted pulse marks a request that found its pending bit clear, so two requests that merge into one pending bit can be told apart. An acknowledge strobe carries a line number and clears only that line, and only if it is edge-sensitive.

Top module: `irql_top`

## Requirements
- R1: A line whose trigger-mode bit is 1 is level-sensitive. After each rising clock edge its pending bit equals the request level sampled at that edge.
- R2: A line whose trigger-mode bit is 0 is edge-sensitive. Its pending bit becomes 1 after an edge where the input is 1 and the level sampled at the previous edge was 0. It then stays 1 when the input falls, and stays 1 until that line is acknowledged.
- R3: The level sampled at the previous edge is recorded for every line. After an edge-sensitive line has been acknowledged, an input that stays high sets its pending bit again only after the input has gone low and then high.
- R4: A request on a line whose mask bit is 1 makes `blocked` for that line 1 for one cycle after the sampling edge. The request still sets the pending bit. A request means a rising edge on an edge-sensitive line, or a high input on a level-sensitive line.
- R5: A mode write stores `mode_wr_data` ANDed with the instance's writable-bits mask: 0xF8 when `SECONDARY` is 0, 0xDE when it is 1. The stored value appears on `trig_mode` after the write edge.
- R6: When `ack_valid` is 1, the pending bit of line `ack_id` is cleared, but only if that line is edge-sensitive. A level-sensitive line stays pending while its input is high. A rising edge that arrives on the same edge as the acknowledge wins, and the bit stays set.
- R7: `accepted` for a line is 1 for one cycle after a sampling edge where that line had a request, its mask bit was 0 and its pending bit was 0. A request that merges into a bit that is already pending gives no `accepted` pulse.
- R8: While reset is held, and until the internal reset synchronizer releases, the trigger mode, pending, status and last-level state are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_in | input | N | Interrupt request levels |
| line_mask | input | N | Per-line mask; 1 reports a request as blocked |
| mode_wr_en | input | 1 | Trigger-mode register write strobe |
| mode_wr_data | input | N | Trigger-mode write data; 1 selects level-sensitive |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_id | input | IDW | Number of the line being acknowledged |
| trig_mode | output | N | Current trigger-mode register |
| pending | output | N | Pending request vector |
| accepted | output | N | One-cycle pulse: request accepted into a clear pending bit |
| blocked | output | N | One-cycle pulse: request arrived on a masked line |

## Verification
The pending bits, the status pulses and the trigger-mode register are all registered. Each of them reflects the inputs held before a rising edge only after that same edge, so every result is due exactly one cycle after its stimulus. The bench drives the inputs just after a falling edge and works out the expected next state before the rising edge. It compares the outputs at the following falling edge, which is one full cycle after the stimulus and away from the edge. After reset is released, the two-flop synchronizer keeps the outputs at zero for two further edges, and the bench steps through that window with its inputs held idle.

// File: rtl/irql_pkg.sv
package irql_pkg;
  // Writable trigger-mode bits for the two instance flavours.
  localparam logic [7:0] PRIMARY_WMASK   = 8'hF8;
  localparam logic [7:0] SECONDARY_WMASK = 8'hDE;

  // Per-line next-state bundle produced by the line cell.
  typedef struct packed {
    logic pend;
    logic acc;
    logic blk;
  } line_state_t;
endpackage

// File: rtl/irql_rst_sync.sv
module irql_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/irql_mode_reg.sv
module irql_mode_reg #(
  parameter int          N     = 8,
  parameter logic [N-1:0] WMASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] wr_data,
  output logic [N-1:0] mode_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (WMASK[i]) begin : g_rw
      logic bit_q, bit_d;
      always_comb begin
        bit_d = bit_q;
        if (wr_en) bit_d = wr_data[i];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     bit_q <= 1'b0;
        else if (wr_en) bit_q <= bit_d;
      end
      assign mode_q[i] = bit_q;
    end else begin : g_fixed
      assign mode_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irql_ack_dec.sv
module irql_ack_dec #(
  parameter int N   = 8,
  parameter int IDW = 3
) (
  input  logic           ack_valid,
  input  logic [IDW-1:0] ack_id,
  output logic [N-1:0]   hit
);
  for (genvar i = 0; i < N; i++) begin : g_hit
    assign hit[i] = ack_valid && (ack_id == IDW'(i));
  end
endmodule

// File: rtl/irql_cell.sv
module irql_cell
  import irql_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic level_mode,
  input  logic masked,
  input  logic ack_hit,
  output logic pend,
  output logic acc,
  output logic blk
);
  logic        last_q, last_d;
  line_state_t st_q, st_d;
  logic        event_now;

  always_comb begin
    event_now = level_mode ? req : (req & ~last_q);
    last_d    = req;
    if (level_mode) st_d.pend = req;
    else            st_d.pend = (st_q.pend & ~ack_hit) | event_now;
    st_d.acc  = event_now & ~masked & ~st_q.pend;
    st_d.blk  = event_now & masked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b0;
      st_q   <= '0;
    end else begin
      last_q <= last_d;
      st_q   <= st_d;
    end
  end

  assign pend = st_q.pend;
  assign acc  = st_q.acc;
  assign blk  = st_q.blk;
endmodule

// File: rtl/irql_top.sv
module irql_top
  import irql_pkg::*;
#(
  parameter int N         = 8,
  parameter bit SECONDARY = 1'b0,
  parameter int IDW       = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   req_in,
  input  logic [N-1:0]   line_mask,
  input  logic           mode_wr_en,
  input  logic [N-1:0]   mode_wr_data,
  input  logic           ack_valid,
  input  logic [IDW-1:0] ack_id,
  output logic [N-1:0]   trig_mode,
  output logic [N-1:0]   pending,
  output logic [N-1:0]   accepted,
  output logic [N-1:0]   blocked
);
  localparam logic [N-1:0] WR_MASK = SECONDARY ? N'(SECONDARY_WMASK) : N'(PRIMARY_WMASK);

  logic         rst_sync_n;
  logic [N-1:0] ack_hit;

  irql_rst_sync u_rst (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_sync_n)
  );

  irql_mode_reg #(.N(N), .WMASK(WR_MASK)) u_mode (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (mode_wr_en),
    .wr_data(mode_wr_data),
    .mode_q (trig_mode)
  );

  irql_ack_dec #(.N(N), .IDW(IDW)) u_ack (
    .ack_valid(ack_valid),
    .ack_id   (ack_id),
    .hit      (ack_hit)
  );

  for (genvar i = 0; i < N; i++) begin : g_line
    irql_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .req       (req_in[i]),
      .level_mode(trig_mode[i]),
      .masked    (line_mask[i]),
      .ack_hit   (ack_hit[i]),
      .pend      (pending[i]),
      .acc       (accepted[i]),
      .blk       (blocked[i])
    );
  end
endmodule

// File: rtl/irql_chk.sv
module irql_chk #(
  parameter int N   = 8,
  parameter int IDW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N-1:0]   req_in,
  input logic [N-1:0]   line_mask,
  input logic           ack_valid,
  input logic [IDW-1:0] ack_id,
  input logic [N-1:0]   trig_mode,
  input logic [N-1:0]   pending,
  input logic [N-1:0]   accepted,
  input logic [N-1:0]   blocked
);
  for (genvar i = 0; i < N; i++) begin : g_prop
    p_level_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(trig_mode[i]) |-> (pending[i] == $past(req_in[i])));

    p_edge_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(trig_mode[i]) && !$past(pending[i]) && pending[i]) |-> $past(req_in[i]));

    p_no_reedge_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n, 2) && !$past(trig_mode[i]) && $past(req_in[i]) &&
       $past(req_in[i], 2) && !$past(pending[i])) |-> !pending[i]);

    p_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
      blocked[i] |-> ($past(line_mask[i]) && pending[i]));

    p_ack_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ack_valid && (ack_id == IDW'(i)) && !trig_mode[i] && !req_in[i]) |-> !pending[i]);

    p_ack_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ack_valid && (ack_id == IDW'(i)) && trig_mode[i] && req_in[i]) |-> pending[i]);

    p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      accepted[i] |-> (pending[i] && !$past(pending[i]) && !$past(line_mask[i])));
  end
endmodule

bind irql_top irql_chk #(.N(N), .IDW(IDW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .req_in   (req_in),
  .line_mask(line_mask),
  .ack_valid(ack_valid),
  .ack_id   (ack_id),
  .trig_mode(trig_mode),
  .pending  (pending),
  .accepted (accepted),
  .blocked  (blocked)
);

// File: tb/sim_irql_top.sv
module sim_irql_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int IDW = 3;
  localparam logic [N-1:0] WM0 = 8'hF8;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] req_in, line_mask, mode_wr_data;
  logic mode_wr_en, ack_valid;
  logic [IDW-1:0] ack_id;
  logic [N-1:0] trig_mode, pending, accepted, blocked;
  logic [N-1:0] trig_mode1, pending1, accepted1, blocked1;

  int total = 0;
  int bad = 0;

  // expected state
  logic [N-1:0] m_mode, m_pend, m_last, m_acc, m_blk;

  always #(CLK_PERIOD/2) clk = ~clk;

  irql_top #(.N(N), .SECONDARY(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .line_mask(line_mask),
    .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data),
    .ack_valid(ack_valid), .ack_id(ack_id),
    .trig_mode(trig_mode), .pending(pending), .accepted(accepted), .blocked(blocked)
  );

  irql_top #(.N(N), .SECONDARY(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .line_mask(line_mask),
    .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data),
    .ack_valid(ack_valid), .ack_id(ack_id),
    .trig_mode(trig_mode1), .pending(pending1), .accepted(accepted1), .blocked(blocked1)
  );

  function automatic logic [N-1:0] f_event(logic [N-1:0] mode, logic [N-1:0] req, logic [N-1:0] last);
    return (mode & req) | (~mode & req & ~last);
  endfunction

  function automatic logic [N-1:0] f_hit(logic v, logic [IDW-1:0] id);
    return v ? (N'(1) << id) : '0;
  endfunction

  function automatic logic [N-1:0] f_pend(logic [N-1:0] mode, logic [N-1:0] pend,
                                          logic [N-1:0] ev, logic [N-1:0] hit, logic [N-1:0] req);
    return (mode & req) | (~mode & ((pend & ~hit) | ev));
  endfunction

  task automatic chk(input string tag, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One clock: predict, cross the rising edge, compare at the falling edge.
  task automatic step(input string tag);
    logic [N-1:0] ev, n_mode, n_pend, n_acc, n_blk;
    ev     = f_event(m_mode, req_in, m_last);
    n_pend = f_pend(m_mode, m_pend, ev, f_hit(ack_valid, ack_id), req_in);
    n_acc  = ev & ~line_mask & ~m_pend;
    n_blk  = ev & line_mask;
    n_mode = mode_wr_en ? (mode_wr_data & WM0) : m_mode;
    @(posedge clk);
    @(negedge clk);
    m_last = req_in;
    m_pend = n_pend;
    m_acc  = n_acc;
    m_blk  = n_blk;
    m_mode = n_mode;
    chk(tag, "pending", pending, m_pend);
    chk(tag, "accepted", accepted, m_acc);
    chk(tag, "blocked", blocked, m_blk);
    chk(tag, "trig_mode", trig_mode, m_mode);
  endtask

  task automatic idle_inputs();
    mode_wr_en = 1'b0; ack_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    req_in = '0; line_mask = '0; mode_wr_data = '0; mode_wr_en = 1'b0;
    ack_valid = 1'b0; ack_id = '0;
    m_mode = '0; m_pend = '0; m_last = '0; m_acc = '0; m_blk = '0;
    #(CLK_PERIOD * 3 + 2);
    // R8: reset state
    chk("R8", "pending in reset", pending, '0);
    chk("R8", "trig_mode in reset", trig_mode, '0);
    chk("R8", "status in reset", accepted | blocked, '0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) step("R8");

    // R5: writability mask on both flavours
    mode_wr_en = 1'b1; mode_wr_data = 8'hFF;
    step("R5");
    chk("R5", "secondary trig_mode", trig_mode1, 8'hDE);
    mode_wr_data = 8'h07;
    step("R5");
    chk("R5", "primary fixed bits", trig_mode, 8'h00);
    chk("R5", "secondary write 07", trig_mode1, 8'h06);
    mode_wr_data = 8'h18;           // lines 3 and 4 level-sensitive
    step("R5");
    idle_inputs();
    mode_wr_data = 8'hFF;           // data without strobe has no effect
    step("R5");

    // R1: level line follows its input
    req_in[3] = 1'b1;
    step("R1"); step("R1"); step("R1");
    req_in[3] = 1'b0;
    step("R1");

    // R2: edge line latches a one-cycle pulse
    req_in[0] = 1'b1;
    step("R2");
    req_in[0] = 1'b0;
    step("R2"); step("R2");

    // R7: second pulse merges into a pending bit, no accepted pulse
    req_in[0] = 1'b1;
    step("R7");
    req_in[0] = 1'b0;
    step("R7");

    // R6: acknowledge edge line clears it; level line stays
    ack_valid = 1'b1; ack_id = 3'd0;
    step("R6");
    req_in[3] = 1'b1;
    step("R6");
    ack_id = 3'd3;
    step("R6"); step("R6");
    ack_valid = 1'b0; req_in[3] = 1'b0;
    step("R6");
    // acknowledge on the same edge as a new rising edge: set wins
    req_in[1] = 1'b1; ack_valid = 1'b1; ack_id = 3'd1;
    step("R6");
    ack_valid = 1'b0;
    step("R6");

    // R3: line 1 held high, acknowledge, no re-trigger without a new edge
    ack_valid = 1'b1; ack_id = 3'd1;
    step("R3");
    ack_valid = 1'b0;
    step("R3"); step("R3"); step("R3");
    req_in[1] = 1'b0;
    step("R3");
    req_in[1] = 1'b1;
    step("R3");
    req_in[1] = 1'b0;

    // R4: masked requests reported as blocked, still pending
    line_mask = 8'h11;
    req_in[4] = 1'b1; req_in[0] = 1'b1;
    step("R4");
    step("R4");
    req_in = '0; line_mask = '0;
    step("R4");
    ack_valid = 1'b1; ack_id = 3'd0;
    step("R4");
    ack_valid = 1'b0;

    // Random phase across all requirements
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] flip;
      flip = N'($urandom) & N'($urandom);
      req_in = req_in ^ flip;
      line_mask = (($urandom % 4) == 0) ? N'($urandom) : line_mask;
      mode_wr_en = (($urandom % 16) == 0);
      mode_wr_data = N'($urandom);
      ack_valid = (($urandom % 3) == 0);
      ack_id = IDW'($urandom);
      case (k % 4)
        0: step("R1");
        1: step("R2");
        2: step("R7");
        default: step("R6");
      endcase
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule